// File: doc/BRIEF.md
# Manchester Word Transmitter with Loopback Check

This block turns 16-bit words into a 1 Mb/s Manchester stream for a dual-redundant serial bus. Each word goes out as a three-bit-time sync pattern, sixteen data bits (most significant first) and an odd parity bit. The sync pattern marks the word as a command/status word or as a data word. A bus select steers the stream onto bus A or bus B. The differential pair and the transmitter inhibit of the bus that is not selected stay in their quiet state. The system clock may run at 12, 16, 20 or 24 MHz, chosen by a two-bit code. The bit timing follows from that code.

Words enter through a valid/ready port. The producer holds `tx_valid` and the word fields steady until a clock edge on which `tx_ready` is also high. The block accepts the word on that edge. While a word is on the line, `tx_ready` rises again only during that word's parity bit, and only if no word is already queued. A word accepted then follows with no gap. Any back-pressure beyond that is the producer's to absorb.

Two monitors run beside the serializer. A watchdog measures how long the transmitter has been on without a break. Past its limit it latches a shutdown, pulses an interrupt, abandons the current and the queued word, and silences both buses until software clears it. A loopback checker holds each finished word. It expects the receiver to report a decode of that word within a bounded window. A mismatch, a reported decode error or no decode at all each produce a one-cycle fail pulse.

Top module: `manchester_word_tx`

## Requirements
- R1: A word occupies exactly 40 half-bit intervals, back to back. Each half-bit lasts 6, 8, 10 or 12 clock cycles for `clk_sel` = 00, 01, 10 or 11, which gives 1 Mb/s at 12, 16, 20 or 24 MHz. After the last half the line returns to idle unless another word is queued.
- R2: Halves 0 to 5 carry the sync. With `tx_sync`=0 (command/status) the line is high for halves 0 to 2 and low for halves 3 to 5. With `tx_sync`=1 (data) the levels are inverted.
- R3: Data bit k (k=0 for bit 15, down to k=15 for bit 0) uses halves 6+2k and 7+2k. A 1 is sent high then low, and a 0 low then high.
- R4: Halves 38 and 39 carry the parity bit, encoded as in R3. It is chosen so that the 16 data bits plus parity hold an odd number of ones.
- R5: On the selected bus (`tx_bus`=0 for A, 1 for B) the positive output follows the line level, the negative output carries its complement, and the inhibit is low. The other bus holds both outputs high with its inhibit high. When nothing is being sent, both buses are in that quiet state.
- R6: `tx_ready` is high when the block is idle. During a transmission it is high only in halves 38 and 39, and only if no word is queued. A word is taken on an edge where `tx_valid` and `tx_ready` are both high, and its half 0 starts in the next cycle.
- R7: A word accepted during the parity bit of the current word starts in the cycle after that word's half 39 ends, with no idle cycle.
- R8: After the transmitter has been on without a break for `WDOG_US` times the cycles per microsecond, `shutdown` latches and `shutdown_irq` pulses for one cycle. In the same cycle the transmission and any queued word are dropped, both buses go quiet and `tx_ready` falls.
- R9: `shutdown` stays high until reset or a cycle with `shutdown_clr` high. While it is high, `tx_ready` is low.
- R10: When a word completes, the checker holds it as pending. If the first `rx_valid` that follows carries the same 16 bits with `rx_err` low, no failure is raised. If the data differ or `rx_err` is high, `loop_fail` pulses for one cycle, starting the cycle after that decode.
- R11: If no `rx_valid` comes within `LB_WAIT` cycles of a word completing, `loop_fail` pulses for one cycle.
- R12: An `rx_valid` that arrives while no word is pending has no effect on `loop_fail`.
- R13: After reset, both buses are quiet, `tx_ready` is high, and `shutdown`, `shutdown_irq` and `loop_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 12/16/20/24 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 2 | Clock rate code: 00=12, 01=16, 10=20, 11=24 MHz; change only while idle |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word can be taken this cycle |
| tx_data | input | 16 | Word payload |
| tx_sync | input | 1 | 0 command/status sync, 1 data sync |
| tx_bus | input | 1 | 0 bus A, 1 bus B |
| shutdown_clr | input | 1 | Clears a latched shutdown |
| bus_a_p | output | 1 | Bus A positive drive |
| bus_a_n | output | 1 | Bus A negative drive |
| bus_a_inh | output | 1 | Bus A transmitter inhibit, active high |
| bus_b_p | output | 1 | Bus B positive drive |
| bus_b_n | output | 1 | Bus B negative drive |
| bus_b_inh | output | 1 | Bus B transmitter inhibit, active high |
| rx_valid | input | 1 | Receiver reports a decoded word |
| rx_data | input | 16 | Decoded word |
| rx_err | input | 1 | Decoded word had a coding or parity error |
| loop_fail | output | 1 | One-cycle pulse: loopback mismatch, error or missing decode |
| shutdown | output | 1 | Transmit watchdog has tripped (sticky) |
| shutdown_irq | output | 1 | One-cycle pulse when the shutdown latches |

## Verification
The bench sweeps every clock-rate code with all-zero, all-one and mixed words, under both sync types on both buses. It samples the middle of every half-bit, so a half-bit one cycle too long or short drifts out of place within a few halves. A swapped sync polarity, an inverted bit encoding, even parity or a stream leaking onto the idle bus each show up at a named half. Words are then queued during the parity bit to catch an idle cycle inserted between consecutive words. The loopback side is driven with a clean echo, a flipped bit, a flagged decode error, silence and a stray decode. A checker that ignores `rx_err`, never times out, or acts on unsolicited decodes miscounts pulses. Three words run back to back exceed a reduced watchdog limit, which exposes a trip that comes early or late, a shutdown that leaves the bus driven, or one that does not hold until cleared.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic {
    SYNC_CMD  = 1'b0,
    SYNC_DATA = 1'b1
  } sync_e;

  typedef struct packed {
    logic [15:0] data;
    sync_e       sync;
    logic        bus;
  } tx_word_t;

  localparam int HALVES_PER_WORD = 40;
  localparam int SYNC_HALVES     = 6;
  localparam int PARITY_HALF     = 38;

endpackage

// File: rtl/mtx_timebase.sv
module mtx_timebase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] clk_sel,
  output logic       half_tick
);
  logic [3:0] cnt;
  logic [3:0] lim;

  // half-bit length minus one: 5,7,9,11 cycles for 12..24 MHz
  assign lim       = 4'd5 + {1'b0, clk_sel, 1'b0};
  assign half_tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (half_tick)  cnt <= '0;
    else                 cnt <= cnt + 4'd1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);  // R1

endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer
  import mtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kill,
  input  logic        half_tick,
  input  logic        in_valid,
  input  tx_word_t    in_word,
  output logic        in_ready,
  output logic        active,
  output logic        line_lvl,
  output logic        cur_bus,
  output logic        done,
  output logic [15:0] done_data
);
  tx_word_t   cur, nxt;
  logic       nxt_v;
  logic [5:0] hidx;
  logic       accept;
  logic       last;

  assign in_ready  = !kill && !nxt_v && (!active || hidx >= 6'(PARITY_HALF));
  assign accept    = in_valid && in_ready;
  assign last      = active && half_tick && (hidx == 6'(HALVES_PER_WORD - 1));
  assign done      = last && !kill;
  assign done_data = cur.data;
  assign cur_bus   = cur.bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hidx   <= '0;
      nxt_v  <= 1'b0;
      cur    <= '0;
      nxt    <= '0;
    end else if (kill) begin
      active <= 1'b0;
      hidx   <= '0;
      nxt_v  <= 1'b0;
    end else if (!active) begin
      if (accept) begin
        cur    <= in_word;
        active <= 1'b1;
        hidx   <= '0;
      end
    end else if (last) begin
      hidx <= '0;
      if (nxt_v) begin
        cur   <= nxt;
        nxt_v <= 1'b0;
      end else if (accept) begin
        cur <= in_word;
      end else begin
        active <= 1'b0;
      end
    end else begin
      if (half_tick) hidx <= hidx + 6'd1;
      if (accept) begin
        nxt   <= in_word;
        nxt_v <= 1'b1;
      end
    end
  end

  // line level for the current half-bit
  logic [5:0] off;
  logic [4:0] bidx;
  logic       bval;
  always_comb begin
    off  = hidx - 6'(SYNC_HALVES);
    bidx = off[5:1];
    bval = (bidx == 5'd16) ? ~^cur.data : cur.data[~bidx[3:0]];
    if (hidx < 6'd3)                    line_lvl = (cur.sync == SYNC_CMD);
    else if (hidx < 6'(SYNC_HALVES))    line_lvl = (cur.sync == SYNC_DATA);
    else                                line_lvl = hidx[0] ? ~bval : bval;
  end

  AST_HIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> hidx < 6'(HALVES_PER_WORD));  // R1
  AST_QUEUE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_v |-> !in_ready);  // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last && nxt_v && !kill) |=> (active && hidx == 6'd0));  // R7
  AST_KILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !active);  // R8

endmodule

// File: rtl/mtx_watchdog.sv
module mtx_watchdog #(
  parameter int WDOG_US = 688
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_on,
  input  logic [1:0] clk_sel,
  input  logic       clr,
  output logic       trip,
  output logic       shut,
  output logic       irq
);
  localparam int UW = $clog2(WDOG_US + 1);

  logic [4:0]    sub;
  logic [4:0]    sub_lim;
  logic [UW-1:0] us;

  // cycles per microsecond minus one: 11,15,19,23
  assign sub_lim = 5'd11 + {1'b0, clk_sel, 2'b00};
  assign trip    = tx_on && !shut && (sub == sub_lim) && (us == UW'(WDOG_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
      us  <= '0;
    end else if (!tx_on || shut || trip) begin
      sub <= '0;
      us  <= '0;
    end else if (sub == sub_lim) begin
      sub <= '0;
      us  <= us + UW'(1);
    end else begin
      sub <= sub + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= trip;
      if (trip)     shut <= 1'b1;
      else if (clr) shut <= 1'b0;
    end
  end

  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && !clr) |=> shut);  // R9
  AST_IRQ_WITH_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> shut);  // R8

endmodule

// File: rtl/mtx_loopcheck.sv
module mtx_loopcheck #(
  parameter int LB_WAIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_done,
  input  logic [15:0] done_data,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  input  logic        rx_err,
  output logic        fail
);
  localparam int TW = $clog2(LB_WAIT + 1);

  logic          pending;
  logic [15:0]   expect_w;
  logic [TW-1:0] tmr;
  logic          bad;

  assign bad = rx_err || (rx_data != expect_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      expect_w <= '0;
      tmr      <= '0;
      fail     <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (word_done) begin
        if (pending) fail <= rx_valid ? bad : 1'b1;
        expect_w <= done_data;
        pending  <= 1'b1;
        tmr      <= '0;
      end else if (pending) begin
        if (rx_valid) begin
          fail    <= bad;
          pending <= 1'b0;
        end else if (tmr == TW'(LB_WAIT - 1)) begin
          fail    <= 1'b1;
          pending <= 1'b0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end

  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(pending));  // R12
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !$past(word_done)) |=> !fail);  // R10

endmodule

// File: rtl/manchester_word_tx.sv
module manchester_word_tx
  import mtx_pkg::*;
#(
  parameter int WDOG_US = 688,
  parameter int LB_WAIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  clk_sel,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [15:0] tx_data,
  input  logic        tx_sync,
  input  logic        tx_bus,
  input  logic        shutdown_clr,
  output logic        bus_a_p,
  output logic        bus_a_n,
  output logic        bus_a_inh,
  output logic        bus_b_p,
  output logic        bus_b_n,
  output logic        bus_b_inh,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  input  logic        rx_err,
  output logic        loop_fail,
  output logic        shutdown,
  output logic        shutdown_irq
);
  localparam int NBUS = 2;

  tx_word_t    in_word;
  logic        half_tick, active, line_lvl, cur_bus, done, trip, kill;
  logic [15:0] done_data;
  logic        drive;
  logic [NBUS-1:0] drv_p, drv_n, drv_inh;

  assign in_word = '{data: tx_data, sync: sync_e'(tx_sync), bus: tx_bus};
  assign kill    = trip || shutdown;
  assign drive   = active && !kill;

  mtx_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .en(active), .clk_sel(clk_sel), .half_tick(half_tick)
  );

  mtx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .kill(kill), .half_tick(half_tick),
    .in_valid(tx_valid), .in_word(in_word), .in_ready(tx_ready),
    .active(active), .line_lvl(line_lvl), .cur_bus(cur_bus),
    .done(done), .done_data(done_data)
  );

  mtx_watchdog #(.WDOG_US(WDOG_US)) u_wd (
    .clk(clk), .rst_n(rst_n), .tx_on(active), .clk_sel(clk_sel),
    .clr(shutdown_clr), .trip(trip), .shut(shutdown), .irq(shutdown_irq)
  );

  mtx_loopcheck #(.LB_WAIT(LB_WAIT)) u_lb (
    .clk(clk), .rst_n(rst_n), .word_done(done), .done_data(done_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .fail(loop_fail)
  );

  // per-bus output gating
  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    logic on;
    assign on         = drive && (cur_bus == 1'(g));
    assign drv_p[g]   = on ? line_lvl  : 1'b1;
    assign drv_n[g]   = on ? ~line_lvl : 1'b1;
    assign drv_inh[g] = ~on;
  end

  assign bus_a_p   = drv_p[0];
  assign bus_a_n   = drv_n[0];
  assign bus_a_inh = drv_inh[0];
  assign bus_b_p   = drv_p[1];
  assign bus_b_n   = drv_n[1];
  assign bus_b_inh = drv_inh[1];

  AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_a_inh && !bus_b_inh));  // R5
  AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
    bus_a_inh |-> (bus_a_p && bus_a_n));  // R5
  AST_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
    bus_b_inh |-> (bus_b_p && bus_b_n));  // R5
  AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (bus_a_inh && bus_b_inh && !tx_ready));  // R9

endmodule

// File: tb/manchester_word_tx_bench.sv
module manchester_word_tx_bench;
  localparam int WD = 50;
  localparam int LBW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic tx_valid = 1'b0, tx_sync = 1'b0, tx_bus = 1'b0, shutdown_clr = 1'b0;
  logic [15:0] tx_data = '0;
  logic rx_valid = 1'b0, rx_err = 1'b0;
  logic [15:0] rx_data = '0;
  logic tx_ready, bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh;
  logic loop_fail, shutdown, shutdown_irq;

  int n_chk = 0, n_err = 0, n_lf = 0, n_irq = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  manchester_word_tx #(.WDOG_US(WD), .LB_WAIT(LBW)) u_manchester_word_tx (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sync(tx_sync), .tx_bus(tx_bus), .shutdown_clr(shutdown_clr),
    .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_a_inh(bus_a_inh),
    .bus_b_p(bus_b_p), .bus_b_n(bus_b_n), .bus_b_inh(bus_b_inh),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .loop_fail(loop_fail), .shutdown(shutdown), .shutdown_irq(shutdown_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && loop_fail) n_lf++;
    if (rst_n && shutdown_irq) n_irq++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {bus_a_p, bus_a_n, bus_a_inh, bus_b_p, bus_b_n, bus_b_inh};
  endfunction

  function automatic bit exp_lvl(logic [15:0] w, bit sy, int h);
    bit b;
    if (h < 3) return !sy;
    if (h < 6) return sy;
    if (h < 38) b = w[15 - ((h - 6) / 2)];
    else        b = ~^w;
    return (h % 2 == 0) ? b : !b;
  endfunction

  function automatic logic [5:0] exp_pins(bit lv, bit bus);
    return bus ? {3'b111, lv, !lv, 1'b0} : {lv, !lv, 1'b0, 3'b111};
  endfunction

  task automatic send(input logic [15:0] w, input bit sy, input bit bus);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = w; tx_sync = sy; tx_bus = bus;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // starts at the accepting edge, ends at the word's final edge
  task automatic run_word(input logic [15:0] w, input bit sy, input bit bus, input int hl, input bit ck_rdy);
    for (int h = 0; h < 40; h++) begin
      logic [5:0] e;
      repeat (hl / 2) @(posedge clk);
      @(negedge clk);
      e = exp_pins(exp_lvl(w, sy, h), bus);
      chk(pins() == e, $sformatf("R1 R5 %s word=%h sync=%0d bus=%0d hl=%0d half=%0d",
          (h < 6) ? "R2" : (h < 38) ? "R3" : "R4", w, sy, bus, hl, h), 32'(pins()), 32'(e));
      if (ck_rdy) chk(tx_ready == (h >= 38), $sformatf("R6 ready half=%0d", h), 32'(tx_ready), 32'(h >= 38));
      repeat (hl - hl / 2) @(posedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] words [4];
    int idx, base, e0;
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hA5C3; words[3] = 16'h8001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(pins() == 6'b111111, "R13 buses quiet", 32'(pins()), 32'h3f);
    chk(tx_ready == 1'b1, "R13 ready", 32'(tx_ready), 1);
    chk({shutdown, shutdown_irq, loop_fail} == 3'b000, "R13 flags", 32'({shutdown, shutdown_irq, loop_fail}), 0);

    // sweep: clock codes x words x sync x bus, loopback modes rotate
    idx = 0;
    for (int s = 0; s < 4; s++) begin
      clk_sel = 2'(s);
      for (int wi = 0; wi < 4; wi++)
        for (int sy = 0; sy < 2; sy++)
          for (int bs = 0; bs < 2; bs++) begin
            int hl;
            hl = 6 + 2 * s;
            send(words[wi], 1'(sy), 1'(bs));
            fork
              run_word(words[wi], 1'(sy), 1'(bs), hl, 1'b1);
              drop();
            join
            base = n_lf;
            @(negedge clk);
            chk(pins() == 6'b111111, "R1 R5 idle after word", 32'(pins()), 32'h3f);
            case (idx % 4)
              0: begin
                rx_valid = 1'b1; rx_data = words[wi]; rx_err = 1'b0;
                @(negedge clk); rx_valid = 1'b0;
                repeat (4) @(negedge clk);
                chk(n_lf == base, "R10 clean echo", 32'(n_lf - base), 0);
                rx_valid = 1'b1; rx_data = ~words[wi]; rx_err = 1'b1;
                @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0;
                repeat (4) @(negedge clk);
                chk(n_lf == base, "R12 stray decode", 32'(n_lf - base), 0);
              end
              1: begin
                rx_valid = 1'b1; rx_data = words[wi] ^ 16'h0100; rx_err = 1'b0;
                @(negedge clk); rx_valid = 1'b0;
                repeat (4) @(negedge clk);
                chk(n_lf == base + 1, "R10 data mismatch", 32'(n_lf - base), 1);
              end
              2: begin
                rx_valid = 1'b1; rx_data = words[wi]; rx_err = 1'b1;
                @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0;
                repeat (4) @(negedge clk);
                chk(n_lf == base + 1, "R10 decode error", 32'(n_lf - base), 1);
              end
              default: begin
                repeat (LBW + 4) @(negedge clk);
                chk(n_lf == base + 1, "R11 missing decode", 32'(n_lf - base), 1);
              end
            endcase
            idx++;
          end
    end

    // R7 back to back at 16 MHz code
    clk_sel = 2'b01;
    send(16'h1234, 1'b0, 1'b0);
    fork
      begin
        run_word(16'h1234, 1'b0, 1'b0, 8, 1'b0);
        run_word(16'hFEDC, 1'b1, 1'b1, 8, 1'b0);
      end
      begin
        drop();
        send(16'hFEDC, 1'b1, 1'b1);
        drop();
      end
    join
    @(negedge clk);
    chk(pins() == 6'b111111, "R7 idle after pair", 32'(pins()), 32'h3f);
    repeat (LBW * 3) @(negedge clk);

    // R8 watchdog: three words at 12 MHz code run 60 us against a 50 us limit
    clk_sel = 2'b00;
    send(16'h0F0F, 1'b0, 1'b0);
    @(negedge clk);
    e0 = cyc;
    send(16'h3C3C, 1'b1, 1'b0);
    send(16'h5555, 1'b1, 1'b0);
    drop();
    while (cyc < e0 + 499) @(negedge clk);
    chk(shutdown == 1'b0, "R8 no early trip", 32'(shutdown), 0);
    chk(bus_a_inh == 1'b0, "R8 still sending", 32'(bus_a_inh), 0);
    while (cyc < e0 + 620) @(negedge clk);
    chk(shutdown == 1'b1, "R8 tripped", 32'(shutdown), 1);
    chk(pins() == 6'b111111, "R8 buses silenced", 32'(pins()), 32'h3f);
    chk(tx_ready == 1'b0, "R8 ready low", 32'(tx_ready), 0);
    chk(n_irq == 1, "R8 one irq pulse", 32'(n_irq), 1);
    repeat (300) @(negedge clk);
    chk(shutdown == 1'b1, "R9 held", 32'(shutdown), 1);
    chk(pins() == 6'b111111, "R8 queued word dropped", 32'(pins()), 32'h3f);
    shutdown_clr = 1'b1;
    @(negedge clk);
    shutdown_clr = 1'b0;
    chk(shutdown == 1'b0, "R9 cleared", 32'(shutdown), 0);
    chk(tx_ready == 1'b1, "R9 ready again", 32'(tx_ready), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule